// File: doc/BRIEF.md
# Wish Branch Fetch Steering Unit

This unit sits in a processor front end. For every fetched wish branch it decides whether the branch is fetched like an ordinary predicted branch or as predicated code. Confidence chooses the style for each dynamic instance. A high-confidence instance redirects fetch along the predicted direction and is repaired by a flush when it resolves the other way. A low-confidence jump or join is fetched straight through with a predicate-mode tag. Correctness then rests on the predicates, so no flush is ever needed for it.

Low-confidence loops are more involved. The unit follows one such loop at a time and counts the loop-branch instances it has fetched. When the loop resolves, it compares the real iteration count with that fetched count. From this it classifies the outcome as exact, early exit, late exit or no exit. It flushes only in the early-exit and no-exit cases.

The direction predictor and the confidence estimator are outside the unit, and both arrive as inputs. The resolution port returns, for each resolved branch, the mode it was fetched in, its predicted and real directions, and the corrected PC. For a predicated loop it also returns the real iteration count.

Top module: `wbs_steer`

## Requirements
- R1: Branch kind codes are 2'b00 plain conditional, 2'b01 wish jump, 2'b10 wish join and 2'b11 wish loop. A plain branch, and any wish branch with `br_conf_high`=1, has `fetch_pred`=0 and `redir_valid`=`br_pred_taken` with `redir_pc`=`br_target`. All of these outputs follow the inputs in the same cycle.
- R2: A resolution with `res_pmode`=0 raises `flush` exactly when `res_taken` differs from `res_pred_taken`, with `flush_pc`=`res_pc`.
- R3: A low-confidence wish jump or wish join gives `fetch_pred`=1 and `redir_valid`=0, whatever the predicted direction.
- R4: A resolution with `res_pmode`=1 for a jump or join never raises `flush`, even when the directions differ, and leaves `loop_class` at 2'b00.
- R5: A low-confidence wish loop is accepted when the loop tracker is idle, or when the tracker is open on the same `br_pc`. An accepted loop gives `fetch_pred`=1 and `redir_valid`=`br_pred_taken`. Its fetched count starts at 1 and grows by one per accepted fetch. A predicted not-taken fetch closes the tracker.
- R6: A low-confidence wish loop is steered as in R1 with `fetch_pred`=0 in three cases: the tracker is closed, the tracker is open on another PC, or a tracked-loop resolution arrives in the same cycle.
- R7: A loop resolution with `res_pmode`=1 on a closed tracker whose `res_iters` exceeds the fetched count is an early exit. It gives `flush`=1 and `loop_class`=2'b01.
- R8: Such a resolution with `res_iters` below the fetched count is a late exit: `flush`=0 and `loop_class`=2'b10. When the two counts are equal it is exact: `flush`=0 and `loop_class`=2'b00.
- R9: A loop resolution with `res_pmode`=1 while the tracker is still open is a no exit. It gives `flush`=1 and `loop_class`=2'b11. Every tracked-loop resolution returns the tracker to idle.
- R10: `flush` is only ever high in a cycle where `res_valid` is high, and it does not depend on any fetch-side input.
- R11: A branch presented in a cycle with `flush`=1 is ignored. It produces no redirect and no predicate tag, and it leaves the tracker unchanged.
- R12: After reset the tracker is idle, and with idle inputs every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch is being fetched |
| br_type | input | 2 | Kind code of the fetched branch |
| br_pc | input | PC_W | PC of the fetched branch |
| br_target | input | PC_W | Taken target of the fetched branch |
| br_pred_taken | input | 1 | Predicted direction |
| br_conf_high | input | 1 | Confidence estimate (tag miss arrives as 0) |
| res_valid | input | 1 | A branch resolves |
| res_type | input | 2 | Kind code of the resolving branch |
| res_pmode | input | 1 | Resolving branch was fetched predicated |
| res_pred_taken | input | 1 | Direction it was predicted |
| res_taken | input | 1 | Real direction |
| res_pc | input | PC_W | Corrected fetch PC |
| res_iters | input | ITER_W | Real iteration count of a predicated loop |
| redir_valid | output | 1 | Redirect next fetch |
| redir_pc | output | PC_W | Redirect PC |
| fetch_pred | output | 1 | Fetched instructions run under predication |
| flush | output | 1 | Flush request |
| flush_pc | output | PC_W | Restart PC on flush |
| loop_class | output | 2 | Loop resolution class |

## Verification
Some properties are checked by assertions on every cycle. A flush never appears without a resolution. A flush cycle never carries a redirect or a predicate tag. Predicated jump and join instances never redirect and never flush. The fetched count grows by exactly one per accepted open-loop fetch.

Other behaviour needs the bench scenarios. These cover the iteration-count classification into early, late, exact and no exit, and the refusal of a second loop while the tracker is busy. They also show that a branch dropped during a flush really left the tracker untouched, which is visible only in later steering.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
   typedef enum logic [1:0] {
      BR_PLAIN = 2'b00,
      BR_JUMP  = 2'b01,
      BR_JOIN  = 2'b10,
      BR_LOOP  = 2'b11
   } br_kind_e;

   typedef enum logic [1:0] {
      TRK_IDLE   = 2'b00,
      TRK_OPEN   = 2'b01,
      TRK_CLOSED = 2'b10
   } trk_state_e;

   typedef enum logic [1:0] {
      LC_NONE   = 2'b00,
      LC_EARLY  = 2'b01,
      LC_LATE   = 2'b10,
      LC_NOEXIT = 2'b11
   } loop_class_e;
endpackage

// File: rtl/wbs_loop_track.sv
module wbs_loop_track
   import wbs_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int ITER_W  = 8,
   parameter bit SAT_CNT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              claim,
   input  logic [PC_W-1:0]   claim_pc,
   input  logic              claim_taken,
   input  logic              done,
   output trk_state_e        state,
   output logic [PC_W-1:0]   trk_pc,
   output logic [ITER_W-1:0] trk_cnt
);
   localparam logic [ITER_W-1:0] CNT_MAX = {ITER_W{1'b1}};
   localparam logic [ITER_W-1:0] CNT_ONE = ITER_W'(1);

   logic [ITER_W-1:0] cnt_inc;

   generate
      if (SAT_CNT) begin : g_sat
         assign cnt_inc = (trk_cnt == CNT_MAX) ? trk_cnt : trk_cnt + CNT_ONE;
      end else begin : g_wrap
         assign cnt_inc = trk_cnt + CNT_ONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= TRK_IDLE;
         trk_pc  <= '0;
         trk_cnt <= '0;
      end else if (done) begin
         state <= TRK_IDLE;
      end else if (claim) begin
         if (state == TRK_IDLE) begin
            trk_pc  <= claim_pc;
            trk_cnt <= CNT_ONE;
         end else begin
            trk_cnt <= cnt_inc;
         end
         state <= claim_taken ? TRK_OPEN : TRK_CLOSED;
      end
   end

   // R5: each accepted fetch on an open loop adds one to the count
   p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (claim && !done && state == TRK_OPEN && trk_cnt != CNT_MAX)
      |=> (trk_cnt == $past(trk_cnt) + CNT_ONE));
   // R11: fetch side never claims while a resolution clears the tracker
   p_claim_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(claim && done));
   // R5: a closed tracker accepts no more fetches
   p_closed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TRK_CLOSED) |-> !claim);
endmodule

// File: rtl/wbs_fetch_decide.sv
module wbs_fetch_decide
   import wbs_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            br_valid,
   input  logic [1:0]      br_type,
   input  logic            br_pred_taken,
   input  logic            br_conf_high,
   input  logic            block,
   input  logic            loop_ok,
   output logic            redir_valid,
   output logic            fetch_pred,
   output logic            claim
);
   logic go, low;
   br_kind_e kind;

   assign kind = br_kind_e'(br_type);
   assign go   = br_valid && !block;
   assign low  = !br_conf_high && (kind != BR_PLAIN);

   always_comb begin
      redir_valid = 1'b0;
      fetch_pred  = 1'b0;
      claim       = 1'b0;
      if (go) begin
         if (low && kind == BR_LOOP && loop_ok) begin
            fetch_pred  = 1'b1;
            claim       = 1'b1;
            redir_valid = br_pred_taken;
         end else if (low && kind != BR_LOOP) begin
            fetch_pred  = 1'b1;
         end else begin
            redir_valid = br_pred_taken;
         end
      end
   end

   // R3: predicated jump/join fetch falls through
   p_jj_fallthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_pred && br_type != 2'b11) |-> !redir_valid);
   // R11: nothing is steered in a blocked cycle
   p_block_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      block |-> (!redir_valid && !fetch_pred && !claim));
endmodule

// File: rtl/wbs_resolve.sv
module wbs_resolve
   import wbs_pkg::*;
#(
   parameter int ITER_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [1:0]        res_type,
   input  logic              res_pmode,
   input  logic              res_pred_taken,
   input  logic              res_taken,
   input  logic [ITER_W-1:0] res_iters,
   input  trk_state_e        state,
   input  logic [ITER_W-1:0] trk_cnt,
   output logic              flush,
   output loop_class_e       cls,
   output logic              done
);
   assign done = res_valid && res_pmode && (res_type == BR_LOOP) && (state != TRK_IDLE);

   always_comb begin
      flush = 1'b0;
      cls   = LC_NONE;
      if (res_valid) begin
         if (!res_pmode) begin
            flush = (res_taken != res_pred_taken);
         end else if (done) begin
            if (state == TRK_OPEN) begin
               flush = 1'b1;
               cls   = LC_NOEXIT;
            end else if (res_iters > trk_cnt) begin
               flush = 1'b1;
               cls   = LC_EARLY;
            end else if (res_iters < trk_cnt) begin
               cls   = LC_LATE;
            end
         end
      end
   end

   // R10: no flush without a resolution
   p_flush_needs_res_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> res_valid);
   // R4: predicated jump/join resolutions never flush
   p_jj_noflush_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_pmode && res_type != 2'b11) |-> (!flush && cls == LC_NONE));
   // R9: a tracked resolution returns the tracker to idle
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (state == TRK_IDLE));
endmodule

// File: rtl/wbs_steer.sv
module wbs_steer
   import wbs_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int ITER_W  = 8,
   parameter bit SAT_CNT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              br_valid,
   input  logic [1:0]        br_type,
   input  logic [PC_W-1:0]   br_pc,
   input  logic [PC_W-1:0]   br_target,
   input  logic              br_pred_taken,
   input  logic              br_conf_high,
   input  logic              res_valid,
   input  logic [1:0]        res_type,
   input  logic              res_pmode,
   input  logic              res_pred_taken,
   input  logic              res_taken,
   input  logic [PC_W-1:0]   res_pc,
   input  logic [ITER_W-1:0] res_iters,
   output logic              redir_valid,
   output logic [PC_W-1:0]   redir_pc,
   output logic              fetch_pred,
   output logic              flush,
   output logic [PC_W-1:0]   flush_pc,
   output logic [1:0]        loop_class
);
   generate
      if (PC_W < 8)   begin : g_bad_pc   $error("PC_W must be at least 8");   end
      if (ITER_W < 2) begin : g_bad_iter $error("ITER_W must be at least 2"); end
   endgenerate

   trk_state_e        state;
   logic [PC_W-1:0]   trk_pc;
   logic [ITER_W-1:0] trk_cnt;
   logic              claim, done, loop_ok;
   loop_class_e       cls;

   assign loop_ok = !done && ((state == TRK_IDLE) ||
                              (state == TRK_OPEN && br_pc == trk_pc));

   wbs_resolve #(.ITER_W(ITER_W)) u_res (
      .clk(clk), .rst_n(rst_n),
      .res_valid(res_valid), .res_type(res_type), .res_pmode(res_pmode),
      .res_pred_taken(res_pred_taken), .res_taken(res_taken),
      .res_iters(res_iters), .state(state), .trk_cnt(trk_cnt),
      .flush(flush), .cls(cls), .done(done)
   );

   wbs_fetch_decide #(.PC_W(PC_W)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .br_valid(br_valid), .br_type(br_type), .br_pred_taken(br_pred_taken),
      .br_conf_high(br_conf_high), .block(flush), .loop_ok(loop_ok),
      .redir_valid(redir_valid), .fetch_pred(fetch_pred), .claim(claim)
   );

   wbs_loop_track #(.PC_W(PC_W), .ITER_W(ITER_W), .SAT_CNT(SAT_CNT)) u_trk (
      .clk(clk), .rst_n(rst_n),
      .claim(claim), .claim_pc(br_pc), .claim_taken(br_pred_taken),
      .done(done), .state(state), .trk_pc(trk_pc), .trk_cnt(trk_cnt)
   );

   assign redir_pc   = br_target;
   assign flush_pc   = res_pc;
   assign loop_class = cls;

   // R11: a flush cycle carries no fetch steering
   p_flush_blocks_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (!redir_valid && !fetch_pred));
   // R1: a high-confidence branch is never predicated
   p_high_not_pred_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_conf_high) |-> !fetch_pred);
endmodule

// File: tb/test_wbs_steer.sv
`timescale 1ns/1ps
module test_wbs_steer;
   localparam int PC_W = 32;
   localparam int ITER_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic br_valid = 0, br_pred_taken = 0, br_conf_high = 0;
   logic [1:0] br_type = 0;
   logic [PC_W-1:0] br_pc = 0, br_target = 0;
   logic res_valid = 0, res_pmode = 0, res_pred_taken = 0, res_taken = 0;
   logic [1:0] res_type = 0;
   logic [PC_W-1:0] res_pc = 0;
   logic [ITER_W-1:0] res_iters = 0;
   logic redir_valid, fetch_pred, flush;
   logic [PC_W-1:0] redir_pc, flush_pc;
   logic [1:0] loop_class;

   int checks = 0, fails = 0;
   int m_st = 0;          // 0 idle, 1 open, 2 closed
   int m_cnt = 0;
   logic [PC_W-1:0] m_pc = 0;

   always #2 clk = ~clk;

   wbs_steer #(.PC_W(PC_W), .ITER_W(ITER_W)) i_wbs_steer (
      .clk(clk), .rst_n(rst_n),
      .br_valid(br_valid), .br_type(br_type), .br_pc(br_pc), .br_target(br_target),
      .br_pred_taken(br_pred_taken), .br_conf_high(br_conf_high),
      .res_valid(res_valid), .res_type(res_type), .res_pmode(res_pmode),
      .res_pred_taken(res_pred_taken), .res_taken(res_taken), .res_pc(res_pc),
      .res_iters(res_iters),
      .redir_valid(redir_valid), .redir_pc(redir_pc), .fetch_pred(fetch_pred),
      .flush(flush), .flush_pc(flush_pc), .loop_class(loop_class)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic clear();
      br_valid = 0; br_type = 0; br_pred_taken = 0; br_conf_high = 0;
      br_pc = 0; br_target = 0;
      res_valid = 0; res_type = 0; res_pmode = 0; res_pred_taken = 0;
      res_taken = 0; res_pc = 0; res_iters = 0;
   endtask

   task automatic br(input logic [1:0] t, input logic [PC_W-1:0] pc, input logic tk, input logic hi);
      br_valid = 1; br_type = t; br_pc = pc; br_target = pc + 32'h40;
      br_pred_taken = tk; br_conf_high = hi;
   endtask

   task automatic res(input logic [1:0] t, input logic pm, input logic pt, input logic tk,
                      input logic [PC_W-1:0] pc, input int it);
      res_valid = 1; res_type = t; res_pmode = pm; res_pred_taken = pt;
      res_taken = tk; res_pc = pc; res_iters = ITER_W'(it);
   endtask

   // one cycle: inputs already driven after a falling edge; compare, advance model
   task automatic tick(input string req);
      logic e_flush, e_redir, e_pred, claim, hit, low;
      int e_cls;
      #1;
      e_flush = 0; e_cls = 0; hit = 0; claim = 0; e_redir = 0; e_pred = 0;
      if (!rst_n) m_st = 0;
      if (rst_n && res_valid) begin
         if (!res_pmode) e_flush = (res_taken != res_pred_taken);
         else if (res_type == 2'b11 && m_st != 0) begin
            hit = 1;
            if (m_st == 1) begin e_flush = 1; e_cls = 3; end
            else if (int'(res_iters) > m_cnt) begin e_flush = 1; e_cls = 1; end
            else if (int'(res_iters) < m_cnt) e_cls = 2;
         end
      end
      low = !br_conf_high && br_type != 2'b00;
      if (rst_n && br_valid && !e_flush) begin
         if (low && br_type == 2'b11 && !hit && (m_st == 0 || (m_st == 1 && br_pc == m_pc))) begin
            e_pred = 1; e_redir = br_pred_taken; claim = 1;
         end else if (low && br_type != 2'b11) e_pred = 1;
         else e_redir = br_pred_taken;
      end
      if (rst_n) begin
         chk(req, "redir_valid", redir_valid, e_redir);
         chk(req, "fetch_pred", fetch_pred, e_pred);
         chk(req, "flush", flush, e_flush);
         chk(req, "loop_class", loop_class, e_cls);
         if (e_redir) chk(req, "redir_pc", redir_pc, br_target);
         if (e_flush) chk(req, "flush_pc", flush_pc, res_pc);
         if (hit) m_st = 0;
         else if (claim) begin
            if (m_st == 0) begin m_pc = br_pc; m_cnt = 1; end
            else if (m_cnt < 255) m_cnt++;
            m_st = br_pred_taken ? 1 : 2;
         end
      end else begin
         chk(req, "reset outputs", {redir_valid, fetch_pred, flush, loop_class}, 0);
      end
      @(negedge clk);
      clear();
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      clear();
      tick("R12"); tick("R12");
      rst_n = 1;
      tick("R12");
      // R1 plain and high-confidence branches
      br(2'b00, 32'h100, 1, 0); tick("R1");
      br(2'b00, 32'h104, 0, 1); tick("R1");
      br(2'b01, 32'h108, 1, 1); tick("R1");
      br(2'b11, 32'h10c, 1, 1); tick("R1");
      // R2 normal resolution
      res(2'b01, 0, 1, 0, 32'h500, 0); tick("R2");
      res(2'b00, 0, 1, 1, 32'h504, 0); tick("R2");
      // R3 low-confidence jump / join
      br(2'b01, 32'h200, 1, 0); tick("R3");
      br(2'b10, 32'h204, 1, 0); tick("R3");
      // R4 predicated jump/join resolution
      res(2'b01, 1, 0, 1, 32'h508, 0); tick("R4");
      res(2'b10, 1, 1, 0, 32'h50c, 0); tick("R4");
      // R5 / R8 exact loop: 3 taken + exit = 4
      for (int i = 0; i < 3; i++) begin br(2'b11, 32'h300, 1, 0); tick("R5"); end
      br(2'b11, 32'h300, 0, 0); tick("R5");
      // R6 closed tracker refuses another loop
      br(2'b11, 32'h340, 1, 0); tick("R6");
      res(2'b11, 1, 0, 0, 32'h600, 4); tick("R8");
      // R7 early exit
      br(2'b11, 32'h300, 1, 0); tick("R5");
      br(2'b11, 32'h300, 0, 0); tick("R5");
      res(2'b11, 1, 0, 1, 32'h604, 5); tick("R7");
      // R8 late exit
      for (int i = 0; i < 4; i++) begin br(2'b11, 32'h380, 1, 0); tick("R5"); end
      br(2'b11, 32'h380, 0, 0); tick("R5");
      res(2'b11, 1, 0, 0, 32'h608, 2); tick("R8");
      // R9 no exit, with R6 different PC while open
      br(2'b11, 32'h3c0, 1, 0); tick("R5");
      br(2'b11, 32'h3e0, 1, 0); tick("R6");
      br(2'b11, 32'h3c0, 1, 0); tick("R5");
      res(2'b11, 1, 1, 0, 32'h60c, 2); tick("R9");
      // R11 branch during flush ignored; tracker must stay idle
      res(2'b00, 0, 0, 1, 32'h610, 0); br(2'b11, 32'h700, 1, 0); tick("R11");
      br(2'b11, 32'h720, 1, 0); tick("R11");
      // R6 tracked resolution plus new low-conf loop in same cycle
      res(2'b11, 1, 1, 0, 32'h614, 1); br(2'b11, 32'h720, 1, 0); tick("R6");
      br(2'b11, 32'h740, 0, 0); tick("R5");
      res(2'b11, 1, 0, 0, 32'h618, 1); tick("R8");
      // R10 flush with no resolution impossible: idle cycles
      tick("R10"); tick("R10");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule